// File: doc/BRIEF.md
# Virtual Interrupt List Register File

This block holds, for each physical processor, a small bank of list entries that a hypervisor fills to present virtual interrupts to a guest. Every entry is a 32-bit word carrying a virtual interrupt number, a linked physical interrupt number, an end-of-interrupt notification flag, a 5-bit priority, a 2-bit life-cycle state, a group flag and a flag marking the entry as tied to a real hardware interrupt. Software reads and writes entries through a simple register port.

The guest side issues operations against the bank of the processor it runs on: a plain lookup, an acknowledge, an end-of-interrupt validation and a deactivate. Each operation searches the bank by virtual number. Results appear one cycle later. When a deactivate hits an entry that is tied to hardware, the block emits a one-cycle clear-active request toward the physical interrupt state. The request passes a range filter, and when security is enabled it also passes a group filter.

Top module: `vlr_file`

## Requirements
- R1: Entry layout: virtual number in bits 9:0, physical number in bits 19:10, notification flag in bit 19, priority in bits 27:23, state in bits 29:28, group in bit 30 and hardware link in bit 31. Written data is stored with bits 22:20 forced to zero, and every other bit reads back as written.
- R2: A write to an index at or above NLR changes no entry. A read of such an index, or of a processor at or above NCPU, returns zero.
- R3: A search returns hit=1 and the lowest index whose virtual number equals the request and whose state is not 0. With no such entry it returns hit=0 and index 0.
- R4: On a hit, the reported priority is the 5-bit field followed by three zero bits, and the group output is bit 30 of the entry. On a miss both are zero.
- R5: Acknowledge on a hit clears state bit 0 and sets state bit 1 of the found entry. The encoding is 0 invalid, 1 pending, 2 active, 3 active-and-pending. A miss changes nothing.
- R6: The ok output of any operation is 1 exactly when some entry with the requested virtual number has state bit 1 set. End-of-interrupt changes no state.
- R7: Deactivate with ok=1 clears state bit 1 of the found entry and keeps its pending bit.
- R8: A deactivate that changes a hardware-linked entry raises fwd_valid one cycle later, with that entry's physical number and the real processor index.
- R9: The forwarded request is dropped when the physical number is below 16 or at or above MAX_IRQ.
- R10: With SEC_EXT=1, the request is forwarded only when bit (cpu*MAX_IRQ + physical number) of phys_grp1 is 1.
- R11: A virtual processor index v at or above NCPU addresses the bank of processor v-NCPU. Lower indices address their own bank.
- R12: When a register write and an operation's state change hit the same entry in one cycle, the written value is stored. The operation's results are computed from the contents before the write.
- R13: res_valid is high exactly in the cycle after op_valid was high.
- R14: After reset, all entries read zero and res_valid and fwd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | CPU_W | Processor bank addressed by the write |
| wr_idx | input | 6 | Entry index addressed by the write |
| wr_data | input | 32 | Entry value to write |
| rd_cpu | input | CPU_W | Processor bank addressed by the read |
| rd_idx | input | 6 | Entry index addressed by the read |
| rd_data | output | 32 | Combinational read value |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 lookup, 1 acknowledge, 2 end-of-interrupt, 3 deactivate |
| op_vcpu | input | VCPU_W | Virtual or physical processor index of the requester |
| op_vid | input | 10 | Virtual interrupt number searched for |
| phys_grp1 | input | NCPU*MAX_IRQ | Group-1 flag per processor and physical interrupt |
| res_valid | output | 1 | Operation result valid |
| res_hit | output | 1 | A live matching entry was found |
| res_idx | output | 6 | Index of the found entry |
| res_prio | output | 8 | Priority of the found entry, scaled to 8 bits |
| res_grp | output | 1 | Group flag of the found entry |
| res_ok | output | 1 | An active matching entry exists |
| fwd_valid | output | 1 | Clear-active request to the physical state |
| fwd_cpu | output | CPU_W | Processor of the forwarded request |
| fwd_pid | output | 10 | Physical interrupt number of the forwarded request |

## Verification
A software write and a guest operation can land on the same entry in the same cycle. For example, an acknowledge or a deactivate can target an entry while the hypervisor rewrites that entry. The bench provokes this directly once, and the random phase produces it often by drawing write and operation targets from small index and number ranges. The outcome is judged by reading the entry back: it must hold the masked write data, while the operation's result outputs and any forwarded request must reflect the entry's contents from before the write.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

  localparam int VID_W  = 10;
  localparam int IDX_W  = 6;
  localparam int NR_SGI = 16;

  localparam int VID_LSB = 0;
  localparam int PID_LSB = 10;
  localparam int PRI_LSB = 23;
  localparam int ST_LSB  = 28;
  localparam int GRP_BIT = 30;
  localparam int HW_BIT  = 31;

  localparam logic [31:0] ENT_WMASK = 32'hFF8F_FFFF;

  typedef enum logic [1:0] {
    OP_LOOK  = 2'd0,
    OP_ACK   = 2'd1,
    OP_EOI   = 2'd2,
    OP_DEACT = 2'd3
  } op_e;

  localparam logic [1:0] ST_INV = 2'd0;

endpackage

// File: rtl/vlr_entry.sv
module vlr_entry (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [31:0] wr_val,
  input  logic        clr_pend,
  input  logic        set_act,
  input  logic        clr_act,
  output logic [31:0] q
);
  import vlr_pkg::*;

  logic [31:0] q_nxt;
  logic        q_en;

  always_comb begin
    q_en  = wr_sel | clr_pend | set_act | clr_act;
    q_nxt = q;
    if (wr_sel) begin
      q_nxt = wr_val;
    end else begin
      if (clr_pend) q_nxt[ST_LSB]   = 1'b0;
      if (set_act)  q_nxt[ST_LSB+1] = 1'b1;
      if (clr_act)  q_nxt[ST_LSB+1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

endmodule

// File: rtl/vlr_match.sv
module vlr_match #(
  parameter int NLR    = 8,
  parameter int LIDX_W = 3
) (
  input  logic [NLR-1:0][11:0] keys,
  input  logic [9:0]           vid,
  output logic                 hit,
  output logic [LIDX_W-1:0]    idx,
  output logic                 act_any
);

  logic [NLR-1:0] live;
  logic [NLR-1:0] actv;

  for (genvar e = 0; e < NLR; e++) begin : g_cmp
    logic same;
    assign same    = (keys[e][9:0] == vid);
    assign live[e] = same && (keys[e][11:10] != 2'd0);
    assign actv[e] = same && keys[e][11];
  end

  always_comb begin
    hit     = |live;
    act_any = |actv;
    idx     = '0;
    for (int i = NLR - 1; i >= 0; i--) begin
      if (live[i]) idx = LIDX_W'(i);
    end
  end

endmodule

// File: rtl/vlr_fwd_filter.sv
module vlr_fwd_filter #(
  parameter int NCPU    = 2,
  parameter int MAX_IRQ = 96,
  parameter bit SEC_EXT = 1'b1,
  parameter int CPU_W   = 1
) (
  input  logic                    cand,
  input  logic [9:0]              pid,
  input  logic [CPU_W-1:0]        cpu,
  input  logic [NCPU*MAX_IRQ-1:0] grp1,
  output logic                    pass
);
  import vlr_pkg::*;

  logic in_range;
  assign in_range = (int'(pid) >= NR_SGI) && (int'(pid) < MAX_IRQ);

  if (SEC_EXT) begin : g_sec
    logic grp_ok;
    always_comb begin
      grp_ok = 1'b0;
      if (in_range && (int'(cpu) < NCPU))
        grp_ok = grp1[int'(cpu) * MAX_IRQ + int'(pid)];
    end
    assign pass = cand && in_range && grp_ok;
  end else begin : g_open
    logic unused_grp;
    assign unused_grp = ^{grp1, cpu};
    assign pass = cand && in_range;
  end

endmodule

// File: rtl/vlr_file.sv
module vlr_file #(
  parameter int NCPU    = 2,
  parameter int NLR     = 8,
  parameter int MAX_IRQ = 96,
  parameter bit SEC_EXT = 1'b1,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int VCPU_W = $clog2(2 * NCPU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CPU_W-1:0]        wr_cpu,
  input  logic [5:0]              wr_idx,
  input  logic [31:0]             wr_data,
  input  logic [CPU_W-1:0]        rd_cpu,
  input  logic [5:0]              rd_idx,
  output logic [31:0]             rd_data,
  input  logic                    op_valid,
  input  logic [1:0]              op_kind,
  input  logic [VCPU_W-1:0]       op_vcpu,
  input  logic [9:0]              op_vid,
  input  logic [NCPU*MAX_IRQ-1:0] phys_grp1,
  output logic                    res_valid,
  output logic                    res_hit,
  output logic [5:0]              res_idx,
  output logic [7:0]              res_prio,
  output logic                    res_grp,
  output logic                    res_ok,
  output logic                    fwd_valid,
  output logic [CPU_W-1:0]        fwd_cpu,
  output logic [9:0]              fwd_pid
);
  import vlr_pkg::*;

  localparam int LIDX_W = (NLR > 1) ? $clog2(NLR) : 1;

  // ---------------- requester processor mapping ----------------
  logic [VCPU_W-1:0] rc_full;
  logic [CPU_W-1:0]  op_cpu;
  logic              op_cpu_ok;

  always_comb begin
    if ({1'b0, op_vcpu} >= (VCPU_W+1)'(NCPU)) rc_full = op_vcpu - VCPU_W'(NCPU);
    else                                      rc_full = op_vcpu;
    op_cpu    = rc_full[CPU_W-1:0];
    op_cpu_ok = ({1'b0, rc_full} < (VCPU_W+1)'(NCPU));
  end

  // ---------------- entry storage ----------------
  logic [31:0]           ent [NCPU][NLR];
  logic [NLR-1:0][11:0]  keys;
  logic                  m_hit;
  logic                  m_act;
  logic [LIDX_W-1:0]     m_idx;
  logic                  ack_fire;
  logic                  deact_fire;
  logic [31:0]           wr_val;

  assign wr_val = wr_data & ENT_WMASK;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar e = 0; e < NLR; e++) begin : g_ent
      logic sel_w;
      logic sel_op;
      assign sel_w  = wr_en && (wr_cpu == CPU_W'(c)) && (wr_idx == 6'(e));
      assign sel_op = (op_cpu == CPU_W'(c)) && (m_idx == LIDX_W'(e));
      vlr_entry i_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (sel_w),
        .wr_val   (wr_val),
        .clr_pend (ack_fire && sel_op),
        .set_act  (ack_fire && sel_op),
        .clr_act  (deact_fire && sel_op),
        .q        (ent[c][e])
      );
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_data = '0;
    if (({1'b0, rd_cpu} < (CPU_W+1)'(NCPU)) && ({1'b0, rd_idx} < 7'(NLR)))
      rd_data = ent[rd_cpu][rd_idx[LIDX_W-1:0]];
  end

  // ---------------- associative search ----------------
  for (genvar e = 0; e < NLR; e++) begin : g_key
    assign keys[e] = op_cpu_ok ? {ent[op_cpu][e][ST_LSB+1:ST_LSB], ent[op_cpu][e][VID_LSB+9:VID_LSB]}
                               : 12'd0;
  end

  vlr_match #(.NLR(NLR), .LIDX_W(LIDX_W)) i_match (
    .keys    (keys),
    .vid     (op_vid),
    .hit     (m_hit),
    .idx     (m_idx),
    .act_any (m_act)
  );

  // ---------------- fields of the found entry ----------------
  logic [4:0] h_pri;
  logic       h_grp;
  logic       h_hw;
  logic [9:0] h_pid;

  always_comb begin
    h_pri = '0;
    h_grp = 1'b0;
    h_hw  = 1'b0;
    h_pid = '0;
    if (m_hit) begin
      h_pri = ent[op_cpu][m_idx][PRI_LSB+4:PRI_LSB];
      h_grp = ent[op_cpu][m_idx][GRP_BIT];
      h_hw  = ent[op_cpu][m_idx][HW_BIT];
      h_pid = ent[op_cpu][m_idx][PID_LSB+9:PID_LSB];
    end
  end

  assign ack_fire   = op_valid && (op_kind == OP_ACK) && m_hit;
  assign deact_fire = op_valid && (op_kind == OP_DEACT) && m_hit && m_act;

  // ---------------- hardware deactivation forward ----------------
  logic fwd_pass;

  vlr_fwd_filter #(.NCPU(NCPU), .MAX_IRQ(MAX_IRQ), .SEC_EXT(SEC_EXT), .CPU_W(CPU_W)) i_filt (
    .cand (deact_fire && h_hw),
    .pid  (h_pid),
    .cpu  (op_cpu),
    .grp1 (phys_grp1),
    .pass (fwd_pass)
  );

  // ---------------- result next state ----------------
  logic       res_hit_d;
  logic [5:0] res_idx_d;
  logic [7:0] res_prio_d;
  logic       res_grp_d;
  logic       res_ok_d;

  always_comb begin
    res_hit_d  = m_hit;
    res_idx_d  = m_hit ? 6'(m_idx) : 6'd0;
    res_prio_d = {h_pri, 3'b000};
    res_grp_d  = h_grp;
    res_ok_d   = m_act;
  end

  // ---------------- result and forward registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_prio  <= '0;
      res_grp   <= 1'b0;
      res_ok    <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_cpu   <= '0;
      fwd_pid   <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_hit  <= res_hit_d;
        res_idx  <= res_idx_d;
        res_prio <= res_prio_d;
        res_grp  <= res_grp_d;
        res_ok   <= res_ok_d;
      end
      fwd_valid <= fwd_pass;
      if (fwd_pass) begin
        fwd_cpu <= op_cpu;
        fwd_pid <= h_pid;
      end
    end
  end

endmodule

// File: rtl/vlr_chk.sv
module vlr_chk #(
  parameter int NLR     = 8,
  parameter int MAX_IRQ = 96
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_kind,
  input logic        res_valid,
  input logic        res_hit,
  input logic [5:0]  res_idx,
  input logic [7:0]  res_prio,
  input logic        res_ok,
  input logic        fwd_valid,
  input logic [9:0]  fwd_pid,
  input logic [31:0] rd_data
);

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[22:20] == 3'b000); // R1
  AST_RES_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> res_valid); // R13
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> !res_valid); // R13
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == 6'd0 && res_prio == 8'd0)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ({1'b0, res_idx} < 7'(NLR))); // R3
  AST_PRIO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> res_prio[2:0] == 3'b000); // R4
  AST_OK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_ok) |-> res_hit); // R6
  AST_FWD_FROM_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(op_valid) && $past(op_kind) == 2'd3)); // R8
  AST_FWD_OK: assert property (@(posedge clk) disable iff (!rst_n) fwd_valid |-> (res_valid && res_ok && res_hit)); // R8
  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (int'(fwd_pid) >= 16 && int'(fwd_pid) < MAX_IRQ)); // R9

endmodule

bind vlr_file vlr_chk #(.NLR(NLR), .MAX_IRQ(MAX_IRQ)) i_vlr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .res_prio  (res_prio),
  .res_ok    (res_ok),
  .fwd_valid (fwd_valid),
  .fwd_pid   (fwd_pid),
  .rd_data   (rd_data)
);

// File: tb/test_vlr_file.sv
`timescale 1ns/100ps
module test_vlr_file;

  localparam int NCPU = 2;
  localparam int NLR  = 8;
  localparam int MAXI = 96;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [0:0]       wr_cpu = '0;
  logic [5:0]       wr_idx = '0;
  logic [31:0]      wr_data = '0;
  logic [0:0]       rd_cpu = '0;
  logic [5:0]       rd_idx = '0;
  logic [31:0]      rd_data;
  logic             op_valid = 1'b0;
  logic [1:0]       op_kind = '0;
  logic [1:0]       op_vcpu = '0;
  logic [9:0]       op_vid = '0;
  logic [NCPU*MAXI-1:0] grp1 = '0;
  logic             res_valid, res_hit, res_grp, res_ok, fwd_valid;
  logic [5:0]       res_idx;
  logic [7:0]       res_prio;
  logic [0:0]       fwd_cpu;
  logic [9:0]       fwd_pid;

  always #2 clk = ~clk;

  vlr_file #(.NCPU(NCPU), .NLR(NLR), .MAX_IRQ(MAXI), .SEC_EXT(1'b1)) i_vlr_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_cpu(rd_cpu), .rd_idx(rd_idx), .rd_data(rd_data),
    .op_valid(op_valid), .op_kind(op_kind), .op_vcpu(op_vcpu), .op_vid(op_vid),
    .phys_grp1(grp1),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_prio(res_prio),
    .res_grp(res_grp), .res_ok(res_ok),
    .fwd_valid(fwd_valid), .fwd_cpu(fwd_cpu), .fwd_pid(fwd_pid)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [NCPU][64];

  function automatic logic [31:0] mk(input int vid, input int pid, input int pri,
                                     input int st, input bit grp, input bit hw);
    logic [31:0] v;
    v = '0;
    v[9:0]   = 10'(vid);
    v[19:10] = 10'(pid);
    v[27:23] = 5'(pri);
    v[29:28] = 2'(st);
    v[30]    = grp;
    v[31]    = hw;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic rdchk(input int c, input int i, input string tag);
    rd_cpu = 1'(c);
    rd_idx = 6'(i);
    #0.2;
    chk(tag, $sformatf("entry %0d/%0d", c, i), rd_data, (i < NLR) ? mdl[c][i] : 32'd0);
  endtask

  // one cycle: drive, predict from the model, check results after the edge
  task automatic step(input bit we, input int wc, input int wi, input logic [31:0] wd,
                      input bit ov, input int kind, input int vc, input int vid);
    int rc, e_idx;
    bit e_hit, e_ok, e_fwd;
    logic [31:0] he;
    @(negedge clk);
    wr_en = we; wr_cpu = 1'(wc); wr_idx = 6'(wi); wr_data = wd;
    op_valid = ov; op_kind = 2'(kind); op_vcpu = 2'(vc); op_vid = 10'(vid);
    rc = (vc >= NCPU) ? vc - NCPU : vc;  // R11 mapping
    e_hit = 0; e_idx = 0; e_ok = 0; e_fwd = 0; he = '0;
    for (int i = NLR - 1; i >= 0; i--) begin
      if (mdl[rc][i][9:0] == 10'(vid) && mdl[rc][i][29:28] != 2'd0) begin
        e_hit = 1; e_idx = i;
      end
      if (mdl[rc][i][9:0] == 10'(vid) && mdl[rc][i][29]) e_ok = 1;
    end
    if (e_hit) he = mdl[rc][e_idx];
    if (ov && kind == 1 && e_hit) begin
      mdl[rc][e_idx][28] = 1'b0;
      mdl[rc][e_idx][29] = 1'b1;
    end
    if (ov && kind == 3 && e_hit && e_ok) begin
      mdl[rc][e_idx][29] = 1'b0;
      if (he[31] && he[19:10] >= 16 && he[19:10] < MAXI && grp1[rc*MAXI + int'(he[19:10])])
        e_fwd = 1;
    end
    if (we && wi < NLR) mdl[wc][wi] = wd & 32'hFF8F_FFFF;  // write wins (R12)
    @(posedge clk);
    #1;
    wr_en = 1'b0; op_valid = 1'b0;
    chk("R13", "res_valid", 32'(res_valid), 32'(ov));
    if (ov) begin
      chk("R3", "res_hit", 32'(res_hit), 32'(e_hit));
      chk("R3", "res_idx", 32'(res_idx), 32'(e_idx));
      chk("R4", "res_prio", 32'(res_prio), e_hit ? 32'({he[27:23], 3'b000}) : 32'd0);
      chk("R4", "res_grp", 32'(res_grp), e_hit ? 32'(he[30]) : 32'd0);
      chk("R6", "res_ok", 32'(res_ok), 32'(e_ok));
    end
    chk("R8", "fwd_valid", 32'(fwd_valid), 32'(e_fwd));
    if (e_fwd) begin
      chk("R8", "fwd_pid", 32'(fwd_pid), 32'(he[19:10]));
      chk("R8", "fwd_cpu", 32'(fwd_cpu), 32'(rc));
    end
    rdchk(rc, e_idx, "R5");
    if (we) rdchk(wc, wi, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCPU; c++) for (int i = 0; i < 64; i++) mdl[c][i] = '0;
    for (int b = 0; b < NCPU*MAXI; b++) grp1[b] = 1'($urandom_range(0, 1));
    grp1[1*MAXI + 40] = 1'b1; grp1[1*MAXI + 41] = 1'b0;
    grp1[1*MAXI + 16] = 1'b1; grp1[1*MAXI + 95] = 1'b1;
    grp1[1*MAXI + 10] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R14 reset state
    chk("R14", "res_valid", 32'(res_valid), 0);
    chk("R14", "fwd_valid", 32'(fwd_valid), 0);
    rdchk(0, 0, "R14"); rdchk(1, 7, "R14");

    // R1 field mask
    step(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rdchk(0, 0, "R1");
    chk("R1", "masked word", rd_data, 32'hFF8F_FFFF);
    // R2 unimplemented index
    step(1, 0, 1, mk(3, 20, 1, 1, 0, 0), 0, 0, 0, 0);
    step(1, 0, 9, 32'h1234_5678, 0, 0, 0, 0);
    rdchk(0, 9, "R2"); rdchk(0, 1, "R2");
    chk("R2", "alias entry", rd_data, mk(3, 20, 1, 1, 0, 0));

    // R3 lowest live match, invalid skipped
    step(1, 0, 2, mk(5, 0, 7, 0, 0, 0), 0, 0, 0, 0);
    step(1, 0, 3, mk(5, 0, 3, 1, 1, 0), 0, 0, 0, 0);
    step(1, 0, 5, mk(5, 0, 9, 1, 0, 0), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 5);
    chk("R3", "first live index", 32'(res_idx), 3);
    chk("R4", "scaled priority", 32'(res_prio), 24);
    step(0, 0, 0, 0, 1, 0, 0, 77);
    chk("R3", "miss hit", 32'(res_hit), 0);
    // R5 acknowledge
    step(0, 0, 0, 0, 1, 1, 0, 5);
    rdchk(0, 3, "R5");
    chk("R5", "state after ack", 32'(rd_data[29:28]), 2);
    // R6 end-of-interrupt validation
    step(0, 0, 0, 0, 1, 2, 0, 5);
    chk("R6", "eoi ok", 32'(res_ok), 1);
    step(0, 0, 0, 0, 1, 2, 0, 3);
    chk("R6", "eoi not active", 32'(res_ok), 0);
    // R7 deactivate keeps pending
    step(1, 0, 4, mk(6, 0, 2, 3, 0, 0), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 0, 6);
    rdchk(0, 4, "R7");
    chk("R7", "state after deact", 32'(rd_data[29:28]), 1);

    // R8 / R9 / R10 hardware forwarding on cpu 1, R11 via vcpu 3
    step(1, 1, 0, mk(9, 40, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 1, 9);
    chk("R8", "forward pid", 32'(fwd_pid), 40);
    step(1, 1, 1, mk(11, 10, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 3, 11);
    chk("R9", "sgi range dropped", 32'(fwd_valid), 0);
    step(1, 1, 1, mk(11, 96, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 3, 11);
    chk("R9", "upper bound dropped", 32'(fwd_valid), 0);
    step(1, 1, 1, mk(11, 16, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 3, 11);
    chk("R9", "pid 16 forwarded", 32'(fwd_valid), 1);
    chk("R11", "mapped cpu", 32'(fwd_cpu), 1);
    step(1, 1, 1, mk(11, 95, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 3, 11);
    chk("R9", "pid 95 forwarded", 32'(fwd_valid), 1);
    step(1, 1, 1, mk(11, 41, 4, 2, 1, 1), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 3, 11);
    chk("R10", "group 0 dropped", 32'(fwd_valid), 0);

    // R12 write and acknowledge on the same entry in one cycle
    step(1, 1, 2, mk(13, 0, 6, 1, 0, 0), 0, 0, 0, 0);
    step(1, 1, 2, mk(14, 0, 1, 1, 1, 0), 1, 1, 3, 13);
    chk("R12", "pre-write priority", 32'(res_prio), 48);
    rdchk(1, 2, "R12");
    chk("R12", "write kept", rd_data, mk(14, 0, 1, 1, 1, 0));

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      d = mk($urandom_range(0, 5), $urandom_range(0, 127), $urandom_range(0, 31),
             $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      d = d | ($urandom & 32'h0078_0000);
      step(1'($urandom_range(0, 1)), $urandom_range(0, 1), $urandom_range(0, 9), d,
           ($urandom_range(0, 9) < 7), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 6));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule